// File: doc/BRIEF.md
# Multithreaded fetch PC sequencer

This block holds one program counter for each hardware thread of an in-order pipeline and hands out fetch addresses. When the fetch stage asks for the next PC of a thread, the block returns the current PC and a per-thread sequence number, then advances both. A later stage can send a target-update command for a control instruction. A return whose target is not yet known (predicted not taken) blocks fetch for that thread until a redirect arrives. A control instruction predicted taken makes the block ask for a squash from that stage.

Squash redirects come in from later stages on several ports. In one cycle, a squash on a port is dropped when a lower-numbered port has already had a squash accepted for the same thread with a sequence number less than or equal to it. An accepted redirect either waits for a trap, if it came from a faulting instruction, or loads the new PC. In the second case it restarts a blocked thread and sends an unblock pulse to the stage that was blocked. Thread activate and trap load the architectural PC. Deactivate parks the thread.

Commands use a valid/ready handshake. `cmd_ready` low means the command stalled, and the requester must hold it and retry. `cmd_ready` depends on the current state and on this cycle's squash inputs only, never on `cmd_valid`. Fetch responses, block, redirect-request and unblock pulses have no back-pressure.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: After reset every thread is invalid, all pulses are low and an assign-next-PC command stalls.
- R2: An assign-next-PC command (`cmd_op`=0) for a valid thread with no accepted squash this cycle completes in the same cycle. `rsp_valid` is high with the current PC and sequence number. The PC then advances by 4 and the sequence number by 1.
- R3: An assign-next-PC command for an invalid thread gives `cmd_ready`=0 and `rsp_valid`=0 and leaves the thread's state unchanged.
- R4: A command with `cmd_fault` set completes at once (`cmd_ready`=1, `rsp_valid`=0). It changes no state and raises no pulse.
- R5: A target-update command (`cmd_op`=1) for a control return predicted not taken invalidates the thread and records its stage. On the next cycle it raises `blk_valid` for one cycle, with that stage and thread.
- R6: A target-update command for a control instruction predicted taken raises `redir_valid` on the next cycle, with the stage and thread. A target update for a non-control instruction has no effect.
- R7: Squash ports are evaluated from index 0 upward. A port's squash is dropped when a lower port already had a squash accepted this cycle for the same thread with a sequence number less than or equal to its own.
- R8: An accepted squash with its fault bit set leaves the thread invalid.
- R9: An accepted non-faulting squash loads its PC into the thread and makes the thread valid. If the thread was invalid, the same port raises `unblk_valid` on the next cycle with the recorded stage and the thread. When several squashes for one thread are accepted in a cycle, the highest accepted port sets the PC.
- R10: Activate or trap for a thread loads `arch_pc` into it and makes it valid.
- R11: Deactivate makes the thread invalid and resets its recorded stage to 0.
- R12: An assign-next-PC command stalls when a squash for the same thread is accepted in the same cycle.
- R13: Effects within one cycle are ranked from highest to lowest: deactivate, activate or trap, squash, command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command completes this cycle (low means stall) |
| cmd_op | input | 1 | 0 assigns the next PC, 1 is a target update |
| cmd_tid | input | 2 | Thread of the command |
| cmd_stage | input | 3 | Stage issuing the command |
| cmd_fault | input | 1 | Instruction already carries a fault |
| cmd_is_ctrl | input | 1 | Instruction is a control instruction |
| cmd_is_ret | input | 1 | Instruction is a return |
| cmd_pred_taken | input | 1 | Instruction is predicted taken |
| rsp_valid | output | 1 | Fetch address handed out |
| rsp_pc | output | 32 | Fetch address |
| rsp_seq | output | 16 | Sequence number of the fetch |
| sq_valid | input | 2 | Squash present, one bit per port |
| sq_tid | input | 4 | Thread per squash port |
| sq_seq | input | 32 | Sequence number per squash port |
| sq_fault | input | 2 | Squash came from a faulting instruction |
| sq_pc | input | 64 | Redirect PC per squash port |
| thr_act_valid | input | 1 | Activate a thread |
| thr_act_tid | input | 2 | Thread to activate |
| trap_valid | input | 1 | Trap taken on a thread |
| trap_tid | input | 2 | Thread of the trap |
| deact_valid | input | 1 | Deactivate a thread |
| deact_tid | input | 2 | Thread to deactivate |
| arch_pc | input | 32 | Architectural PC for activate and trap |
| blk_valid | output | 1 | Block pulse |
| blk_stage | output | 3 | Stage to block |
| blk_tid | output | 2 | Thread to block |
| redir_valid | output | 1 | Squash-request pulse |
| redir_stage | output | 3 | Stage squashing |
| redir_tid | output | 2 | Thread squashing |
| unblk_valid | output | 2 | Unblock pulse per squash port |
| unblk_stage | output | 6 | Stage to unblock per port |
| unblk_tid | output | 4 | Thread to unblock per port |

## Verification
The assertions assume that every input is known at each clock edge after reset. They also assume that a thread named on a control input is present, which always holds with four threads and 2-bit IDs. The deactivate assertion only looks at the cycle right after a deactivate that had no activate or trap beside it. The bench changes inputs only on the falling edge. It keeps activate, trap and deactivate rare, so that blocked threads and stalls stay visible. It draws squash sequence numbers from a small range, so that equal and out-of-order pairs on the two ports occur often.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic {
    OP_NEXT_PC = 1'b0,
    OP_TARGET  = 1'b1
  } fps_op_e;
endpackage

// File: rtl/fps_cmd_decode.sv
module fps_cmd_decode
  import fps_pkg::*;
(
  input  logic cmd_valid,
  input  logic cmd_op,
  input  logic cmd_fault,
  input  logic cmd_is_ctrl,
  input  logic cmd_is_ret,
  input  logic cmd_pred_taken,
  output logic is_target,
  output logic want_next,
  output logic want_block,
  output logic want_redir
);
  fps_op_e op_e;
  logic    live;

  assign op_e      = fps_op_e'(cmd_op);
  assign is_target = (op_e == OP_TARGET);
  assign live      = cmd_valid && !cmd_fault;

  always_comb begin
    want_next  = 1'b0;
    want_block = 1'b0;
    want_redir = 1'b0;
    if (live) begin
      unique case (op_e)
        OP_NEXT_PC: want_next = 1'b1;
        OP_TARGET: begin
          if (cmd_is_ctrl) begin
            if (cmd_is_ret && !cmd_pred_taken) want_block = 1'b1;
            else if (cmd_pred_taken)           want_redir = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fps_squash_filter.sv
module fps_squash_filter #(
  parameter int NT      = 4,
  parameter int P       = 2,
  parameter int PC_W    = 32,
  parameter int SEQ_W   = 16,
  parameter int STAGE_W = 3,
  parameter int TID_W   = 2
) (
  input  logic [P-1:0]         sq_valid,
  input  logic [P*TID_W-1:0]   sq_tid,
  input  logic [P*SEQ_W-1:0]   sq_seq,
  input  logic [P-1:0]         sq_fault,
  input  logic [P*PC_W-1:0]    sq_pc,
  input  logic [NT-1:0]        v_in,
  input  logic [STAGE_W-1:0]   stage_in [NT],
  output logic [NT-1:0]        hit,
  output logic [NT-1:0]        pc_load,
  output logic [PC_W-1:0]      pc_new   [NT],
  output logic [NT-1:0]        v_out,
  output logic [P-1:0]         unb_valid,
  output logic [STAGE_W-1:0]   unb_stage [P]
);
  logic [SEQ_W-1:0] lo_seq [NT];
  logic [TID_W-1:0] cur_t;
  logic [SEQ_W-1:0] cur_seq;
  logic             accept;

  always_comb begin
    hit     = '0;
    pc_load = '0;
    v_out   = v_in;
    cur_t   = '0;
    cur_seq = '0;
    accept  = 1'b0;
    for (int t = 0; t < NT; t++) begin
      lo_seq[t] = '0;
      pc_new[t] = '0;
    end
    for (int p = 0; p < P; p++) begin
      unb_valid[p] = 1'b0;
      unb_stage[p] = '0;
    end
    for (int p = 0; p < P; p++) begin
      cur_t   = sq_tid[p*TID_W +: TID_W];
      cur_seq = sq_seq[p*SEQ_W +: SEQ_W];
      accept  = sq_valid[p] && !(hit[cur_t] && (lo_seq[cur_t] <= cur_seq));
      if (accept) begin
        hit[cur_t]    = 1'b1;
        lo_seq[cur_t] = cur_seq;
        if (sq_fault[p]) begin
          v_out[cur_t] = 1'b0;
        end else begin
          pc_load[cur_t] = 1'b1;
          pc_new[cur_t]  = sq_pc[p*PC_W +: PC_W];
          if (!v_out[cur_t]) begin
            unb_valid[p] = 1'b1;
            unb_stage[p] = stage_in[cur_t];
          end
          v_out[cur_t] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fps_thread_ctx.sv
module fps_thread_ctx #(
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int STAGE_W    = 3,
  parameter int INSN_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               blk_set,
  input  logic [STAGE_W-1:0] blk_stage_in,
  input  logic               pc_load,
  input  logic [PC_W-1:0]    pc_new,
  input  logic               v_next,
  input  logic               arch_load,
  input  logic [PC_W-1:0]    arch_pc,
  input  logic               deact,
  output logic [PC_W-1:0]    pc,
  output logic [SEQ_W-1:0]   seq,
  output logic               valid,
  output logic [STAGE_W-1:0] stage
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      seq   <= '0;
      valid <= 1'b0;
      stage <= '0;
    end else begin
      if (adv) seq <= seq + 1'b1;

      if (arch_load)    pc <= arch_pc;
      else if (pc_load) pc <= pc_new;
      else if (adv)     pc <= pc + STEP;

      if (deact)          valid <= 1'b0;
      else if (arch_load) valid <= 1'b1;
      else                valid <= v_next;

      if (deact)        stage <= '0;
      else if (blk_set) stage <= blk_stage_in;
    end
  end
endmodule

// File: rtl/fetch_pc_sequencer.sv
module fetch_pc_sequencer #(
  parameter int NUM_THREADS = 4,
  parameter int SQ_PORTS    = 2,
  parameter int PC_W        = 32,
  parameter int SEQ_W       = 16,
  parameter int STAGE_W     = 3,
  parameter int INSN_BYTES  = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic                        cmd_op,
  input  logic [TID_W-1:0]            cmd_tid,
  input  logic [STAGE_W-1:0]          cmd_stage,
  input  logic                        cmd_fault,
  input  logic                        cmd_is_ctrl,
  input  logic                        cmd_is_ret,
  input  logic                        cmd_pred_taken,
  output logic                        rsp_valid,
  output logic [PC_W-1:0]             rsp_pc,
  output logic [SEQ_W-1:0]            rsp_seq,
  input  logic [SQ_PORTS-1:0]         sq_valid,
  input  logic [SQ_PORTS*TID_W-1:0]   sq_tid,
  input  logic [SQ_PORTS*SEQ_W-1:0]   sq_seq,
  input  logic [SQ_PORTS-1:0]         sq_fault,
  input  logic [SQ_PORTS*PC_W-1:0]    sq_pc,
  input  logic                        thr_act_valid,
  input  logic [TID_W-1:0]            thr_act_tid,
  input  logic                        trap_valid,
  input  logic [TID_W-1:0]            trap_tid,
  input  logic                        deact_valid,
  input  logic [TID_W-1:0]            deact_tid,
  input  logic [PC_W-1:0]             arch_pc,
  output logic                        blk_valid,
  output logic [STAGE_W-1:0]          blk_stage,
  output logic [TID_W-1:0]            blk_tid,
  output logic                        redir_valid,
  output logic [STAGE_W-1:0]          redir_stage,
  output logic [TID_W-1:0]            redir_tid,
  output logic [SQ_PORTS-1:0]         unblk_valid,
  output logic [SQ_PORTS*STAGE_W-1:0] unblk_stage,
  output logic [SQ_PORTS*TID_W-1:0]   unblk_tid
);
  logic is_target, want_next, want_block, want_redir;

  logic [PC_W-1:0]    thr_pc    [NUM_THREADS];
  logic [SEQ_W-1:0]   thr_seq   [NUM_THREADS];
  logic [STAGE_W-1:0] thr_stage [NUM_THREADS];
  logic [STAGE_W-1:0] stage_pre [NUM_THREADS];
  logic [PC_W-1:0]    sq_pc_new [NUM_THREADS];
  logic [NUM_THREADS-1:0] thr_valid, v_pre, v_post, sq_hit, sq_pc_ld;
  logic [NUM_THREADS-1:0] adv, blk_set, arch_ld, deact_hit;
  logic [SQ_PORTS-1:0]    unb_c;
  logic [STAGE_W-1:0]     unb_stage_c [SQ_PORTS];

  fps_cmd_decode u_dec (
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .cmd_fault      (cmd_fault),
    .cmd_is_ctrl    (cmd_is_ctrl),
    .cmd_is_ret     (cmd_is_ret),
    .cmd_pred_taken (cmd_pred_taken),
    .is_target      (is_target),
    .want_next      (want_next),
    .want_block     (want_block),
    .want_redir     (want_redir)
  );

  fps_squash_filter #(
    .NT(NUM_THREADS), .P(SQ_PORTS), .PC_W(PC_W), .SEQ_W(SEQ_W),
    .STAGE_W(STAGE_W), .TID_W(TID_W)
  ) u_filt (
    .sq_valid  (sq_valid),
    .sq_tid    (sq_tid),
    .sq_seq    (sq_seq),
    .sq_fault  (sq_fault),
    .sq_pc     (sq_pc),
    .v_in      (v_pre),
    .stage_in  (stage_pre),
    .hit       (sq_hit),
    .pc_load   (sq_pc_ld),
    .pc_new    (sq_pc_new),
    .v_out     (v_post),
    .unb_valid (unb_c),
    .unb_stage (unb_stage_c)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic sel_c;
    assign sel_c        = (cmd_tid == TID_W'(t));
    assign adv[t]       = want_next && sel_c && thr_valid[t] && !sq_hit[t];
    assign blk_set[t]   = want_block && sel_c;
    assign v_pre[t]     = thr_valid[t] && !blk_set[t];
    assign stage_pre[t] = blk_set[t] ? cmd_stage : thr_stage[t];
    assign arch_ld[t]   = (thr_act_valid && (thr_act_tid == TID_W'(t))) ||
                          (trap_valid && (trap_tid == TID_W'(t)));
    assign deact_hit[t] = deact_valid && (deact_tid == TID_W'(t));

    fps_thread_ctx #(
      .PC_W(PC_W), .SEQ_W(SEQ_W), .STAGE_W(STAGE_W), .INSN_BYTES(INSN_BYTES)
    ) u_ctx (
      .clk          (clk),
      .rst_n        (rst_n),
      .adv          (adv[t]),
      .blk_set      (blk_set[t]),
      .blk_stage_in (cmd_stage),
      .pc_load      (sq_pc_ld[t]),
      .pc_new       (sq_pc_new[t]),
      .v_next       (v_post[t]),
      .arch_load    (arch_ld[t]),
      .arch_pc      (arch_pc),
      .deact        (deact_hit[t]),
      .pc           (thr_pc[t]),
      .seq          (thr_seq[t]),
      .valid        (thr_valid[t]),
      .stage        (thr_stage[t])
    );
  end

  assign cmd_ready = is_target || cmd_fault ||
                     (thr_valid[cmd_tid] && !sq_hit[cmd_tid]);
  assign rsp_valid = want_next && cmd_ready;
  assign rsp_pc    = thr_pc[cmd_tid];
  assign rsp_seq   = thr_seq[cmd_tid];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_valid   <= 1'b0;
      blk_stage   <= '0;
      blk_tid     <= '0;
      redir_valid <= 1'b0;
      redir_stage <= '0;
      redir_tid   <= '0;
    end else begin
      blk_valid   <= want_block;
      blk_stage   <= cmd_stage;
      blk_tid     <= cmd_tid;
      redir_valid <= want_redir;
      redir_stage <= cmd_stage;
      redir_tid   <= cmd_tid;
    end
  end

  for (genvar p = 0; p < SQ_PORTS; p++) begin : g_unb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        unblk_valid[p]                      <= 1'b0;
        unblk_stage[p*STAGE_W +: STAGE_W]   <= '0;
        unblk_tid[p*TID_W +: TID_W]         <= '0;
      end else begin
        unblk_valid[p]                      <= unb_c[p];
        unblk_stage[p*STAGE_W +: STAGE_W]   <= unb_stage_c[p];
        unblk_tid[p*TID_W +: TID_W]         <= sq_tid[p*TID_W +: TID_W];
      end
    end
  end
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int NUM_THREADS = 4,
  parameter int SQ_PORTS    = 2,
  parameter int SEQ_W       = 16,
  parameter int STAGE_W     = 3,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_valid,
  input logic                      cmd_ready,
  input logic                      cmd_op,
  input logic [TID_W-1:0]          cmd_tid,
  input logic [STAGE_W-1:0]        cmd_stage,
  input logic                      cmd_fault,
  input logic                      cmd_is_ctrl,
  input logic                      cmd_is_ret,
  input logic                      cmd_pred_taken,
  input logic                      rsp_valid,
  input logic [SQ_PORTS-1:0]       sq_valid,
  input logic [SQ_PORTS*TID_W-1:0] sq_tid,
  input logic [SQ_PORTS*SEQ_W-1:0] sq_seq,
  input logic                      thr_act_valid,
  input logic                      trap_valid,
  input logic                      deact_valid,
  input logic [TID_W-1:0]          deact_tid,
  input logic                      blk_valid,
  input logic [STAGE_W-1:0]        blk_stage,
  input logic                      redir_valid,
  input logic [SQ_PORTS-1:0]       unblk_valid
);
  logic ret_unknown;
  assign ret_unknown = cmd_valid && cmd_op && !cmd_fault && cmd_is_ctrl &&
                       cmd_is_ret && !cmd_pred_taken;

  assert_rsp_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cmd_valid && cmd_ready && !cmd_op && !cmd_fault));

  assert_fault_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_fault) |-> (cmd_ready && !rsp_valid));

  assert_block_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_unknown |=> (blk_valid && blk_stage == $past(cmd_stage)));

  assert_no_ctrl_no_redir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op && !cmd_is_ctrl) |=> !redir_valid);

  assert_deact_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_op && !cmd_fault && $past(deact_valid) &&
     !$past(thr_act_valid) && !$past(trap_valid) &&
     cmd_tid == $past(deact_tid)) |-> !cmd_ready);

  if (SQ_PORTS >= 2) begin : g_dup
    assert_dup_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_valid[0] && sq_valid[1] &&
       sq_tid[0 +: TID_W] == sq_tid[TID_W +: TID_W] &&
       sq_seq[0 +: SEQ_W] <= sq_seq[SEQ_W +: SEQ_W]) |=> !unblk_valid[1]);
  end
endmodule

bind fetch_pc_sequencer fps_checker #(
  .NUM_THREADS(NUM_THREADS), .SQ_PORTS(SQ_PORTS), .SEQ_W(SEQ_W), .STAGE_W(STAGE_W)
) u_chk (.*);

// File: tb/fetch_pc_sequencer_bench.sv
`timescale 1ns/1ps
module fetch_pc_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_op, cmd_fault, cmd_is_ctrl, cmd_is_ret, cmd_pred_taken;
  logic [1:0]  cmd_tid;
  logic [2:0]  cmd_stage;
  logic        cmd_ready, rsp_valid;
  logic [31:0] rsp_pc;
  logic [15:0] rsp_seq;
  logic [1:0]  sq_valid, sq_fault;
  logic [3:0]  sq_tid;
  logic [31:0] sq_seq;
  logic [63:0] sq_pc;
  logic        thr_act_valid, trap_valid, deact_valid;
  logic [1:0]  thr_act_tid, trap_tid, deact_tid;
  logic [31:0] arch_pc;
  logic        blk_valid, redir_valid;
  logic [2:0]  blk_stage, redir_stage;
  logic [1:0]  blk_tid, redir_tid, unblk_valid;
  logic [5:0]  unblk_stage;
  logic [3:0]  unblk_tid;

  always #5 clk = ~clk;

  fetch_pc_sequencer u_fetch_pc_sequencer (.*);

  int    n_checks = 0;
  int    n_err    = 0;
  bit    finished = 0;
  string cur_tag  = "R1";

  logic [31:0] m_pc    [4];
  logic [15:0] m_seq   [4];
  bit          m_v     [4];
  logic [2:0]  m_stage [4];
  bit          e_blk_v, e_rd_v;
  logic [2:0]  e_blk_s, e_rd_s;
  logic [1:0]  e_blk_t, e_rd_t;
  bit          e_unb_v [2];
  logic [2:0]  e_unb_s [2];
  logic [1:0]  e_unb_t [2];

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
    end
  endtask

  task automatic idle();
    cmd_valid = 0; cmd_op = 0; cmd_fault = 0; cmd_is_ctrl = 0; cmd_is_ret = 0;
    cmd_pred_taken = 0; cmd_tid = 0; cmd_stage = 0;
    sq_valid = 0; sq_fault = 0; sq_tid = 0; sq_seq = 0; sq_pc = 0;
    thr_act_valid = 0; trap_valid = 0; deact_valid = 0;
    thr_act_tid = 0; trap_tid = 0; deact_tid = 0; arch_pc = 0;
  endtask

  task automatic cmd(bit op, int tid, int stage, bit flt, bit ctrl, bit ret, bit tk);
    cmd_valid = 1; cmd_op = op; cmd_tid = 2'(tid); cmd_stage = 3'(stage);
    cmd_fault = flt; cmd_is_ctrl = ctrl; cmd_is_ret = ret; cmd_pred_taken = tk;
  endtask

  task automatic sq(int p, int tid, int seq, bit flt, logic [31:0] pc);
    sq_valid[p] = 1; sq_tid[p*2 +: 2] = 2'(tid); sq_seq[p*16 +: 16] = 16'(seq);
    sq_fault[p] = flt; sq_pc[p*32 +: 32] = pc;
  endtask

  task automatic cycle();
    bit          hit [4];
    logic [15:0] lo  [4];
    bit          acc [2];
    bit          exp_ready, exp_rsp;
    logic [31:0] npc [4];
    logic [15:0] nseq [4];
    bit          nv [4];
    logic [2:0]  nst [4];
    bit          n_blk, n_rd;
    bit          n_unb [2];
    logic [2:0]  n_unb_s [2];
    int t;
    #4;
    for (int i = 0; i < 4; i++) begin
      hit[i] = 0; lo[i] = 0;
      npc[i] = m_pc[i]; nseq[i] = m_seq[i]; nv[i] = m_v[i]; nst[i] = m_stage[i];
    end
    for (int p = 0; p < 2; p++) begin
      int st = sq_tid[p*2 +: 2];
      acc[p] = sq_valid[p] && !(hit[st] && lo[st] <= sq_seq[p*16 +: 16]);
      if (acc[p]) begin hit[st] = 1; lo[st] = sq_seq[p*16 +: 16]; end
    end
    t = cmd_tid;
    if (cmd_fault || cmd_op) exp_ready = 1;
    else exp_ready = m_v[t] && !hit[t];
    exp_rsp = cmd_valid && !cmd_op && !cmd_fault && exp_ready;
    if (cmd_valid) chk("cmd_ready", cmd_ready, exp_ready);
    chk("rsp_valid", rsp_valid, exp_rsp);
    if (exp_rsp) begin
      chk("rsp_pc", rsp_pc, m_pc[t]);
      chk("rsp_seq", rsp_seq, m_seq[t]);
    end
    chk("blk_valid", blk_valid, e_blk_v);
    if (e_blk_v) begin chk("blk_stage", blk_stage, e_blk_s); chk("blk_tid", blk_tid, e_blk_t); end
    chk("redir_valid", redir_valid, e_rd_v);
    if (e_rd_v) begin chk("redir_stage", redir_stage, e_rd_s); chk("redir_tid", redir_tid, e_rd_t); end
    for (int p = 0; p < 2; p++) begin
      chk($sformatf("unblk_valid[%0d]", p), unblk_valid[p], e_unb_v[p]);
      if (e_unb_v[p]) begin
        chk("unblk_stage", unblk_stage[p*3 +: 3], e_unb_s[p]);
        chk("unblk_tid", unblk_tid[p*2 +: 2], e_unb_t[p]);
      end
    end
    if (exp_rsp) begin npc[t] = m_pc[t] + 4; nseq[t] = m_seq[t] + 1; end
    n_blk = cmd_valid && !cmd_fault && cmd_op && cmd_is_ctrl && cmd_is_ret && !cmd_pred_taken;
    n_rd  = cmd_valid && !cmd_fault && cmd_op && cmd_is_ctrl && cmd_pred_taken;
    if (n_blk) begin nv[t] = 0; nst[t] = cmd_stage; end
    for (int p = 0; p < 2; p++) begin
      int st = sq_tid[p*2 +: 2];
      n_unb[p] = 0; n_unb_s[p] = 0;
      if (acc[p]) begin
        if (sq_fault[p]) nv[st] = 0;
        else begin
          npc[st] = sq_pc[p*32 +: 32];
          if (!nv[st]) begin n_unb[p] = 1; n_unb_s[p] = nst[st]; end
          nv[st] = 1;
        end
      end
    end
    if (thr_act_valid) begin npc[thr_act_tid] = arch_pc; nv[thr_act_tid] = 1; end
    if (trap_valid)    begin npc[trap_tid] = arch_pc;    nv[trap_tid] = 1;    end
    if (deact_valid)   begin nv[deact_tid] = 0; nst[deact_tid] = 0; end
    e_blk_v = n_blk; e_blk_s = cmd_stage; e_blk_t = cmd_tid;
    e_rd_v  = n_rd;  e_rd_s  = cmd_stage; e_rd_t  = cmd_tid;
    for (int p = 0; p < 2; p++) begin
      e_unb_v[p] = n_unb[p]; e_unb_s[p] = n_unb_s[p]; e_unb_t[p] = sq_tid[p*2 +: 2];
    end
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      m_pc[i] = npc[i]; m_seq[i] = nseq[i]; m_v[i] = nv[i]; m_stage[i] = nst[i];
    end
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL %s watchdog: actual timeout expected completion", cur_tag);
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    for (int i = 0; i < 4; i++) begin m_pc[i] = 0; m_seq[i] = 0; m_v[i] = 0; m_stage[i] = 0; end
    e_blk_v = 0; e_rd_v = 0; e_blk_s = 0; e_rd_s = 0; e_blk_t = 0; e_rd_t = 0;
    for (int p = 0; p < 2; p++) begin e_unb_v[p] = 0; e_unb_s[p] = 0; e_unb_t[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    cur_tag = "R1";  cmd(0, 0, 0, 0, 0, 0, 0); cycle(); cycle();
    cur_tag = "R10"; thr_act_valid = 1; thr_act_tid = 0; arch_pc = 32'h1000; cycle();
                     trap_valid = 1; trap_tid = 1; arch_pc = 32'h2000; cycle();
    cur_tag = "R2";  for (int i = 0; i < 3; i++) begin cmd(0, 0, 1, 0, 0, 0, 0); cycle(); end
                     cmd(0, 1, 1, 0, 0, 0, 0); cycle();
    cur_tag = "R4";  cmd(0, 0, 1, 1, 0, 0, 0); cycle();
                     cmd(1, 0, 4, 1, 1, 1, 0); cycle(); cmd(0, 0, 1, 0, 0, 0, 0); cycle();
    cur_tag = "R3";  cmd(0, 2, 1, 0, 0, 0, 0); cycle();
    cur_tag = "R5";  cmd(1, 0, 3, 0, 1, 1, 0); cycle(); cmd(0, 0, 1, 0, 0, 0, 0); cycle();
    cur_tag = "R9";  sq(0, 0, 5, 0, 32'h3000); cycle(); cmd(0, 0, 1, 0, 0, 0, 0); cycle();
                     sq(1, 0, 2, 0, 32'h3400); cycle();
    cur_tag = "R6";  cmd(1, 1, 2, 0, 1, 0, 1); cycle(); cmd(1, 1, 2, 0, 0, 0, 1); cycle();
                     cmd(1, 1, 6, 0, 1, 1, 1); cycle(); cycle();
    cur_tag = "R7";  cmd(1, 1, 4, 0, 1, 1, 0); cycle();
                     sq(0, 1, 7, 0, 32'h4000); sq(1, 1, 7, 0, 32'h5000); cycle();
                     cmd(0, 1, 1, 0, 0, 0, 0); cycle();
                     sq(0, 1, 9, 0, 32'h6000); sq(1, 1, 4, 0, 32'h7000); cycle();
                     cmd(0, 1, 1, 0, 0, 0, 0); cycle();
    cur_tag = "R12"; sq(0, 1, 3, 0, 32'h8000); cmd(0, 1, 1, 0, 0, 0, 0); cycle();
                     cmd(0, 1, 1, 0, 0, 0, 0); cycle();
    cur_tag = "R8";  sq(1, 1, 3, 1, 32'h9000); cycle(); cmd(0, 1, 1, 0, 0, 0, 0); cycle();
    cur_tag = "R11"; cmd(1, 0, 5, 0, 1, 1, 0); cycle();
                     deact_valid = 1; deact_tid = 0; cycle();
                     cmd(0, 0, 1, 0, 0, 0, 0); cycle();
                     sq(0, 0, 1, 0, 32'hA000); cycle(); cycle();
    cur_tag = "R13"; deact_valid = 1; deact_tid = 2; thr_act_valid = 1; thr_act_tid = 2;
                     arch_pc = 32'hB000; cycle(); cmd(0, 2, 1, 0, 0, 0, 0); cycle();
                     thr_act_valid = 1; thr_act_tid = 2; arch_pc = 32'hC000;
                     sq(0, 2, 1, 0, 32'hD000); cycle(); cmd(0, 2, 1, 0, 0, 0, 0); cycle();

    cur_tag = "R2";
    for (int i = 0; i < 4; i++) begin
      thr_act_valid = 1; thr_act_tid = 2'(i); arch_pc = 32'(i * 32'h100);
      cycle();
    end
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 2 == 0) begin
        cmd(1'($urandom % 2), int'($urandom % 4), int'($urandom % 8),
            ($urandom % 8) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
            ($urandom % 2) == 0);
      end
      for (int p = 0; p < 2; p++)
        if ($urandom % 4 == 0)
          sq(p, int'($urandom % 4), int'($urandom % 8), ($urandom % 6) == 0,
             32'($urandom) & 32'hFFFF_FFFC);
      if ($urandom % 16 == 0) begin thr_act_valid = 1; thr_act_tid = 2'($urandom); end
      if ($urandom % 32 == 0) begin trap_valid = 1; trap_tid = 2'($urandom); end
      if ($urandom % 32 == 0) begin deact_valid = 1; deact_tid = 2'($urandom); end
      arch_pc = 32'($urandom) & 32'hFFFF_FFFC;
      cycle();
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule